// File: doc/BRIEF.md
# Path-Oblivious Memory Access Controller

This block serves single-word read and write requests while hiding which logical address each one touches. Data blocks live in a binary tree of buckets, each bucket holding a fixed number of slots. A position map on the chip assigns every logical address to one leaf of the tree, and a small plaintext stash holds blocks that are in transit. Every accepted request follows the same sequence. The controller looks up the leaf and moves every real block on that root-to-leaf path into the stash. It then serves the request from the stash and gives the block a new random leaf. Last, it writes the same path back, placing stash blocks as deep as their leaf tags allow.

When stash occupancy reaches a threshold, the controller stops accepting requests and runs dummy evictions on random paths. A dummy eviction produces the same bus sequence and takes the same number of cycles as a real access. It leaves every block unchanged, so waiting stash blocks can drain without revealing that the stash was close to full. Random leaves come from a 32-bit maximal-length LFSR that steps once per access, real or dummy.

The control state machine has five states:
- `ST_IDLE` goes to `ST_READ` on a dummy start or on an accepted request.
- `ST_READ` walks the path one slot per cycle and goes to `ST_SERVE` after the last slot.
- `ST_SERVE` lasts one cycle and goes to `ST_WRITE`.
- `ST_WRITE` walks the path leaf-first and goes to `ST_DONE` after the last slot.
- `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `oram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_valid`, `rsp_valid`, `stash_count` and `stash_overflow` are all 0.
- R2: A read of an address that has never been written returns 0.
- R3: A read returns the data most recently written to that address, whatever real or dummy accesses came in between.
- R4: Every access, real or dummy, has the same bus form. First come PATH=(LEVELS+1)*Z read cycles on one root-to-leaf path, root level first and slots in ascending order within each bucket. Then comes exactly one idle bus cycle. Then come PATH write cycles on the same path, leaf level first. Buckets use heap numbering: the root is node 0 and the children of node n are 2n+1 and 2n+2. The slot index is node*Z+slot.
- R5: For a read, `rsp_valid` is high for exactly one cycle, 2*PATH+2 cycles after the cycle in which the request is accepted.
- R6: Each access gives the touched block a new leaf drawn from a non-zero 32-bit LFSR. Repeated accesses to one address therefore visit more than one leaf.
- R7: `req_ready` is 0 whenever `stash_count` is at or above THRESH. In that case the controller starts dummy evictions with no request present, and each one has the R4 bus form.
- R8: A dummy eviction never raises `stash_count`, and the stash count changes by at most one per cycle.
- R9: `stash_overflow` is sticky once set, and it stays 0 while the stash has room for every block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Logical address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | DW | Read data |
| bus_valid | output | 1 | Tree slot access this cycle |
| bus_write | output | 1 | Slot access is a write |
| bus_slot | output | SLW | Tree slot index, node*Z+slot |
| stash_count | output | CNW | Number of occupied stash entries |
| stash_overflow | output | 1 | Sticky flag: a block found no stash entry |

## Verification
A wrong position-map entry or a lost stash block shows at the ports as stale or zero read data. This appears on the first read of the affected address, at the fixed response cycle. A broken path walk or a wrong dummy sequence shows within the same access as a slot index that leaves the root-to-leaf chain, a write path that differs from the read path, or a missing idle cycle between the two phases. A broken eviction trigger shows as `req_ready` high while `stash_count` sits at or above the threshold, or as a dummy pass after which the count has grown.

// File: rtl/oram_pkg.sv
package oram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_SERVE,
        ST_WRITE,
        ST_DONE
    } oram_state_t;

    // Galois feedback mask for x^32 + x^22 + x^2 + x + 1
    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
    endfunction

endpackage

// File: rtl/oram_lfsr.sv
module oram_lfsr #(
    parameter logic [31:0] SEED = 32'h1ACE_B00C,
    parameter int          OW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [OW-1:0] rnd
);
    import oram_pkg::*;

    logic [31:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (step)
            state_q <= lfsr_next(state_q);
    end

    assign rnd = state_q[OW-1:0];

    // R6
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'd0);

endmodule

// File: rtl/oram_posmap.sv
module oram_posmap #(
    parameter int          AW   = 4,
    parameter int          LV   = 3,
    parameter logic [31:0] SEED = 32'h1ACE_B00C,
    localparam int         NADDR = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [LV-1:0] rd_leaf,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [LV-1:0] wr_leaf
);
    import oram_pkg::*;

    logic [LV-1:0] pm [NADDR];

    function automatic logic [LV-1:0] start_leaf(input int a);
        logic [31:0] s;
        s = ~SEED;
        for (int k = 0; k <= a; k++) s = lfsr_next(s);
        return s[LV-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NADDR; a++) pm[a] <= start_leaf(a);
        end else if (wr_en) begin
            pm[wr_addr] <= wr_leaf;
        end
    end

    assign rd_leaf = pm[rd_addr];

endmodule

// File: rtl/oram_tree.sv
module oram_tree #(
    parameter int  AW = 4,
    parameter int  DW = 8,
    parameter int  LV = 3,
    parameter int  Z  = 2,
    localparam int NSLOT = ((2 << LV) - 1) * Z,
    localparam int SLW   = $clog2(NSLOT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SLW-1:0] idx,
    output logic           rd_vld,
    output logic [AW-1:0]  rd_addr,
    output logic [LV-1:0]  rd_leaf,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic           wr_vld,
    input  logic [AW-1:0]  wr_addr,
    input  logic [LV-1:0]  wr_leaf,
    input  logic [DW-1:0]  wr_data
);
    logic [NSLOT-1:0] vld;
    logic [AW-1:0]    ad [NSLOT];
    logic [LV-1:0]    tg [NSLOT];
    logic [DW-1:0]    dt [NSLOT];

    always_ff @(posedge clk) begin
        if (!rst_n)
            vld <= '0;
        else if (wr_en)
            vld[idx] <= wr_vld;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ad[idx] <= wr_addr;
            tg[idx] <= wr_leaf;
            dt[idx] <= wr_data;
        end
    end

    assign rd_vld  = vld[idx];
    assign rd_addr = ad[idx];
    assign rd_leaf = tg[idx];
    assign rd_data = dt[idx];

endmodule

// File: rtl/oram_stash.sv
module oram_stash #(
    parameter int  AW = 4,
    parameter int  DW = 8,
    parameter int  LV = 3,
    parameter int  SN = 16,
    localparam int IW  = $clog2(SN),
    localparam int CNW = $clog2(SN + 1),
    localparam int LVW = $clog2(LV + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_en,
    input  logic [AW-1:0]  ins_addr,
    input  logic [LV-1:0]  ins_leaf,
    input  logic [DW-1:0]  ins_data,
    input  logic [AW-1:0]  look_addr,
    output logic           hit,
    output logic [DW-1:0]  hit_data,
    input  logic           put_en,
    input  logic [LV-1:0]  put_leaf,
    input  logic [DW-1:0]  put_data,
    input  logic [LV-1:0]  path_leaf,
    input  logic [LVW-1:0] level,
    output logic           ev_found,
    output logic [AW-1:0]  ev_addr,
    output logic [LV-1:0]  ev_leaf,
    output logic [DW-1:0]  ev_data,
    input  logic           ev_take,
    output logic           full,
    output logic [CNW-1:0] count
);
    logic [SN-1:0]  vld;
    logic [AW-1:0]  ad [SN];
    logic [LV-1:0]  tg [SN];
    logic [DW-1:0]  dt [SN];
    logic [SN-1:0]  hit_vec;
    logic           free_ok;
    logic [IW-1:0]  free_idx, hit_idx, ev_idx, put_idx;
    logic           ins_go, put_go;

    // Scan from the top index down so the lowest matching entry wins.
    always_comb begin : g_scan
        int sh;
        sh       = LV - int'(level);
        free_ok  = 1'b0;
        free_idx = '0;
        hit      = 1'b0;
        hit_idx  = '0;
        ev_found = 1'b0;
        ev_idx   = '0;
        for (int i = SN - 1; i >= 0; i--) begin
            hit_vec[i] = vld[i] && (ad[i] == look_addr);
            if (!vld[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (vld[i] && ((tg[i] >> sh) == (path_leaf >> sh))) begin
                ev_found = 1'b1;
                ev_idx   = IW'(i);
            end
        end
    end

    assign put_idx  = hit ? hit_idx : free_idx;
    assign ins_go   = ins_en && free_ok;
    assign put_go   = put_en && (hit || free_ok);
    assign hit_data = dt[hit_idx];
    assign ev_addr  = ad[ev_idx];
    assign ev_leaf  = tg[ev_idx];
    assign ev_data  = dt[ev_idx];
    assign full     = !free_ok;
    assign count    = CNW'($countones(vld));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (ins_go) vld[free_idx] <= 1'b1;
            if (put_go) vld[put_idx] <= 1'b1;
            if (ev_take && ev_found) vld[ev_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_go) begin
            ad[free_idx] <= ins_addr;
            tg[free_idx] <= ins_leaf;
            dt[free_idx] <= ins_data;
        end
        if (put_go) begin
            ad[put_idx] <= look_addr;
            tg[put_idx] <= put_leaf;
            dt[put_idx] <= put_data;
        end
    end

    // R3
    uniq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/oram_ctrl.sv
module oram_ctrl #(
    parameter int          AW     = 4,
    parameter int          DW     = 8,
    parameter int          LV     = 3,
    parameter int          Z      = 2,
    parameter int          SN     = 16,
    parameter int          THRESH = 3,
    parameter logic [31:0] SEED   = 32'h1ACE_B00C,
    localparam int         NSLOT  = ((2 << LV) - 1) * Z,
    localparam int         SLW    = $clog2(NSLOT),
    localparam int         PATH   = (LV + 1) * Z,
    localparam int         CW     = $clog2(PATH),
    localparam int         CNW    = $clog2(SN + 1),
    localparam int         LVW    = $clog2(LV + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_rdata,
    output logic           bus_valid,
    output logic           bus_write,
    output logic [SLW-1:0] bus_slot,
    output logic [CNW-1:0] stash_count,
    output logic           stash_overflow
);
    import oram_pkg::*;

    oram_state_t    state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [LV-1:0]  leaf_q;
    logic [AW-1:0]  addr_q;
    logic           write_q, dummy_q, ovf_q;
    logic [DW-1:0]  wdata_q, rdata_q;

    logic [LVW-1:0] lvl;
    logic [SLW-1:0] idx;
    logic           start_dummy, accept, last_slot;
    logic           ins_en, put_en, ev_take, t_we, pm_we, lfsr_step;

    logic [LV-1:0]  rnd, pm_leaf;
    logic           t_vld;
    logic [AW-1:0]  t_addr;
    logic [LV-1:0]  t_leaf;
    logic [DW-1:0]  t_data;
    logic           s_hit, s_full, ev_found;
    logic [DW-1:0]  s_hit_data, ev_data, put_data;
    logic [AW-1:0]  ev_addr;
    logic [LV-1:0]  ev_leaf;
    logic [CNW-1:0] s_count;

    // Path position: read phase goes root first, write phase leaf first.
    always_comb begin : g_path
        int l, s, node;
        l    = (state_q == ST_WRITE) ? (LV - int'(cnt_q) / Z) : (int'(cnt_q) / Z);
        s    = int'(cnt_q) % Z;
        node = (1 << l) - 1 + (int'(leaf_q) >> (LV - l));
        lvl  = LVW'(l);
        idx  = SLW'(node * Z + s);
    end

    assign last_slot   = (cnt_q == CW'(PATH - 1));
    assign start_dummy = (state_q == ST_IDLE) && (s_count >= CNW'(THRESH));
    assign accept      = req_valid && req_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_dummy || accept) state_d = ST_READ;
            ST_READ:  if (last_slot) state_d = ST_SERVE;
            ST_SERVE: state_d = ST_WRITE;
            ST_WRITE: if (last_slot) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and per-state controls
    always_comb begin
        req_ready = (state_q == ST_IDLE) && (s_count < CNW'(THRESH));
        bus_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
        bus_write = (state_q == ST_WRITE);
        rsp_valid = (state_q == ST_DONE) && !dummy_q && !write_q;
        ins_en    = (state_q == ST_READ) && t_vld;
        put_en    = (state_q == ST_SERVE) && !dummy_q;
        pm_we     = put_en;
        t_we      = (state_q == ST_WRITE);
        ev_take   = t_we && ev_found;
        lfsr_step = start_dummy || put_en;
    end

    assign put_data       = write_q ? wdata_q : (s_hit ? s_hit_data : '0);
    assign bus_slot       = idx;
    assign rsp_rdata      = rdata_q;
    assign stash_count    = s_count;
    assign stash_overflow = ovf_q;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            leaf_q  <= '0;
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            dummy_q <= 1'b0;
            rdata_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (start_dummy) begin
                        dummy_q <= 1'b1;
                        write_q <= 1'b0;
                        leaf_q  <= rnd;
                    end else if (accept) begin
                        dummy_q <= 1'b0;
                        write_q <= req_write;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        leaf_q  <= pm_leaf;
                    end
                end
                ST_READ: begin
                    cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
                    if (t_vld && s_full) ovf_q <= 1'b1;
                end
                ST_SERVE: begin
                    cnt_q <= '0;
                    if (!dummy_q) begin
                        rdata_q <= s_hit ? s_hit_data : '0;
                        if (!s_hit && s_full) ovf_q <= 1'b1;
                    end
                end
                ST_WRITE: cnt_q <= last_slot ? '0 : cnt_q + 1'b1;
                ST_DONE:  cnt_q <= '0;
                default:  cnt_q <= '0;
            endcase
        end
    end

    oram_lfsr #(.SEED(SEED), .OW(LV)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (lfsr_step),
        .rnd   (rnd)
    );

    oram_posmap #(.AW(AW), .LV(LV), .SEED(SEED)) u_posmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (req_addr),
        .rd_leaf (pm_leaf),
        .wr_en   (pm_we),
        .wr_addr (addr_q),
        .wr_leaf (rnd)
    );

    oram_tree #(.AW(AW), .DW(DW), .LV(LV), .Z(Z)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx),
        .rd_vld  (t_vld),
        .rd_addr (t_addr),
        .rd_leaf (t_leaf),
        .rd_data (t_data),
        .wr_en   (t_we),
        .wr_vld  (ev_found),
        .wr_addr (ev_addr),
        .wr_leaf (ev_leaf),
        .wr_data (ev_data)
    );

    oram_stash #(.AW(AW), .DW(DW), .LV(LV), .SN(SN)) u_stash (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_en    (ins_en),
        .ins_addr  (t_addr),
        .ins_leaf  (t_leaf),
        .ins_data  (t_data),
        .look_addr (addr_q),
        .hit       (s_hit),
        .hit_data  (s_hit_data),
        .put_en    (put_en),
        .put_leaf  (rnd),
        .put_data  (put_data),
        .path_leaf (leaf_q),
        .level     (lvl),
        .ev_found  (ev_found),
        .ev_addr   (ev_addr),
        .ev_leaf   (ev_leaf),
        .ev_data   (ev_data),
        .ev_take   (ev_take),
        .full      (s_full),
        .count     (s_count)
    );

    // R7
    evict_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && stash_count >= CNW'(THRESH)) |=> !req_ready);

    // R4
    phase_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_write) |-> (!$past(bus_valid) && $past(bus_valid, 2)));

    // R5
    rsp_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(bus_write) && !bus_valid));

    // R8
    occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stash_count == $past(stash_count)) ||
        (stash_count == $past(stash_count) + 1'b1) ||
        (stash_count == $past(stash_count) - 1'b1));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(stash_overflow));

endmodule

// File: tb/sim_oram_ctrl.sv
`timescale 1ns/1ps
module sim_oram_ctrl;
    localparam int AW = 4, DW = 8, LV = 3, Z = 2, SN = 16, TH = 3;
    localparam int PATH = (LV + 1) * Z;
    localparam int SLW = 5, CNW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_ready, rsp_valid, bus_valid, bus_write, stash_overflow;
    logic [DW-1:0]  rsp_rdata;
    logic [SLW-1:0] bus_slot;
    logic [CNW-1:0] stash_count;

    always #4 clk = ~clk;

    oram_ctrl #(.AW(AW), .DW(DW), .LV(LV), .Z(Z), .SN(SN), .THRESH(TH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_slot(bus_slot),
        .stash_count(stash_count), .stash_overflow(stash_overflow)
    );

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bus monitor
    int rd_idx [PATH];
    int wr_idx [PATH];
    int nodes [LV+1];
    int rk = 0, wk = 0, gap = 0, cnt_start = 0, last_leaf = 0;
    int bursts = 0, dummies = 0, gate_bad = 0, dummy_grow = 0;
    bit pend_acc = 0, cur_dummy = 0, end_pend = 0;

    task automatic check_burst();
        bit ok;
        ok = (gap == 1) && (rk == PATH);
        for (int k = 0; k < PATH; k++) begin
            int l, s, n;
            l = k / Z; s = k % Z; n = rd_idx[k] / Z;
            if (rd_idx[k] % Z != s) ok = 0;
            if (n < (1 << l) - 1 || n > (1 << (l + 1)) - 2) ok = 0;
            if (s == 0) begin
                if (l > 0 && (n - 1) / 2 != nodes[l-1]) ok = 0;
                nodes[l] = n;
            end else if (n != nodes[l]) ok = 0;
        end
        for (int k = 0; k < PATH; k++) begin
            int l, s;
            l = LV - k / Z; s = k % Z;
            if (wr_idx[k] % Z != s || wr_idx[k] / Z != nodes[l]) ok = 0;
        end
        last_leaf = nodes[LV] - ((1 << LV) - 1);
        bursts++;
        if (cur_dummy) dummies++;
        check(ok, cur_dummy ? "R7 dummy burst has R4 form" : "R4 path burst form", gap, 1);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (int'(stash_count) >= TH && req_ready) gate_bad++;
            if (end_pend) begin
                end_pend = 0;
                if (cur_dummy && int'(stash_count) > cnt_start) dummy_grow++;
            end
            if (bus_valid && !bus_write) begin
                if (rk == 0) begin
                    cur_dummy = !pend_acc;
                    pend_acc  = 0;
                    cnt_start = int'(stash_count);
                end
                if (rk < PATH) rd_idx[rk] = int'(bus_slot);
                rk++;
            end else if (bus_valid && bus_write) begin
                if (wk < PATH) wr_idx[wk] = int'(bus_slot);
                wk++;
                if (wk == PATH) begin
                    check_burst();
                    rk = 0; wk = 0; gap = 0;
                    end_pend = 1;
                end
            end else if (rk > 0) begin
                gap++;
            end
            if (req_valid && req_ready) pend_acc = 1;
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cyc > 150000 && !finished) begin
            finished = 1;
            check(0, "watchdog expired", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic access(input bit wr, input int a, input int d, output int rd, output int lat);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr;
        req_addr = AW'(a); req_wdata = DW'(d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
        rd = -1; lat = 0;
        if (!wr) begin
            do begin
                @(negedge clk);
                lat++;
            end while (!rsp_valid && lat < 200);
            rd = int'(rsp_rdata);
        end
    endtask

    int model [1 << AW];

    task automatic test_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
        check(bus_valid == 1'b0, "R1 bus idle after reset", int'(bus_valid), 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        check(stash_count == '0, "R1 stash empty after reset", int'(stash_count), 0);
        check(stash_overflow == 1'b0, "R1 overflow clear after reset", int'(stash_overflow), 0);
    endtask

    task automatic test_fresh();
        int rd, lat;
        access(0, 9, 0, rd, lat);
        check(rd == 0, "R2 unwritten address 9 reads zero", rd, 0);
        access(0, 3, 0, rd, lat);
        check(rd == 0, "R2 unwritten address 3 reads zero", rd, 0);
    endtask

    task automatic test_write_read();
        int rd, lat;
        access(1, 7, 8'hA5, rd, lat);
        model[7] = 8'hA5;
        access(0, 7, 0, rd, lat);
        check(rd == 8'hA5, "R3 read after write", rd, 8'hA5);
        check(lat == 2 * PATH + 2, "R5 response latency", lat, 2 * PATH + 2);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R5 response is one cycle wide", int'(rsp_valid), 0);
        access(1, 7, 8'h3C, rd, lat);
        model[7] = 8'h3C;
        access(0, 7, 0, rd, lat);
        check(rd == 8'h3C, "R3 overwrite returns new data", rd, 8'h3C);
    endtask

    task automatic test_remap();
        int rd, lat, first, distinct;
        distinct = 0; first = -1;
        for (int i = 0; i < 10; i++) begin
            access(0, 2, 0, rd, lat);
            if (first < 0) first = last_leaf;
            else if (last_leaf != first) distinct = 1;
        end
        check(distinct == 1, "R6 repeated accesses visit several leaves", distinct, 1);
    endtask

    task automatic test_mixed();
        int rd, lat, a, d;
        logic [31:0] rs;
        rs = 32'h2468_ACE1;
        for (int a0 = 0; a0 < (1 << AW); a0++) begin
            model[a0] = (a0 * 37 + 11) & 8'hFF;
            access(1, a0, model[a0], rd, lat);
        end
        for (int i = 0; i < 160; i++) begin
            rs = rs * 32'd1103515245 + 32'd12345;
            a = int'(rs[19:16]);
            d = int'(rs[27:20]);
            if (rs[30]) begin
                access(1, a, d, rd, lat);
                model[a] = d;
            end else begin
                access(0, a, 0, rd, lat);
                check(rd == model[a], "R3 mixed traffic read data", rd, model[a]);
            end
        end
        repeat (2 * PATH + 4) @(negedge clk);
        check(dummies > 0, "R7 dummy evictions occurred", dummies, 1);
        check(gate_bad == 0, "R7 req_ready low at threshold", gate_bad, 0);
        check(dummy_grow == 0, "R8 dummy never raises stash count", dummy_grow, 0);
        check(stash_overflow == 1'b0, "R9 no overflow with ample stash", int'(stash_overflow), 0);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset();
        test_fresh();
        test_write_read();
        test_remap();
        test_mixed();
        check(bursts > 0, "R4 bursts observed", bursts, 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule